// File: doc/BRIEF.md
# Priority-Based Pin Function Multiplexer

This block decides, for a set of eight multi-function pins, which signal owns each pin. Software writes a bank of twelve 32-bit control registers over a small address/data bus. Two read-only strap words that the hardware samples at power-up are also visible on the bus. For each pin the block evaluates one enable per priority level. An enable is an OR of AND-terms, and those terms mix single control bits, bits spread over several registers, multi-bit field compares and strap bits. The highest level whose enable is true wins. When no level is enabled, the pin falls back to its last signal.

The winning level is held in a register and reported as a 3-bit code per pin. The same code steers one of three candidate source signals (level 0, level 1, fallback) onto the pin's drive output. The fallback is not always a GPIO: on one pin the GPIO is the top level and a network clock is the fallback.

Top module: `pin_function_mux`

## Requirements
- R1: Synchronous active-low reset clears every writable control register to zero and sets every pin selection code to 7. With the strap bits at 14 = 0, 19 = 1 and 6 = 1, all eight pins report 7 after reset.
- R2: The writable registers sit at byte offsets 0x2C, 0x3C, 0x48, 0x80, 0x84, 0x88, 0x8C, 0x90, 0x94, 0xA0, 0xA4 and 0xA8. A write is captured on the clock edge where `bus_we` is high, and reading the offset returns the stored word.
- R3: Offset 0x70 reads `strap_a` and offset 0xD0 reads `strap_b`. Writes to either offset change no register and no pin selection.
- R4: Any other offset reads zero, and a write to it changes no register.
- R5: A pin selection changes on the clock edge after the edge that captured the altering write (or after a strap input change). It does not change on the capturing edge itself.
- R6: Pin 0 selects level 0 when 0x90 bit 22 is 1. Otherwise it selects level 1 when 0x80 bit 4 is 1, and otherwise 7. A lower level is reported only while every higher level's enable is false.
- R7: Pin 1 selects level 0 when 0x80 bit 12 is 1 OR strap bit 14 is 1, and otherwise 7. Pin 2 selects level 0 when 0x80 bit 25 is 1. Otherwise it selects level 1 when 0xA4 bit 12 is 1 OR strap bit 19 is 0, and otherwise 7.
- R8: Pin 3 requires 0x3C bit 3 and 0x80 bit 15 both at 1. With 0x90 bit 31 = 0 it selects level 0, with 0x90 bit 31 = 1 it selects level 1, and with either required bit at 0 it selects 7.
- R9: The field 0x90[5:4] sets the video mode (0 off, 1/2/3 = 18/24/30-bit). Pin 4 selects level 0 when the field is nonzero and 0x84 bit 17 is 1, level 1 when only 0x84 bit 17 is 1, and otherwise 7. Pins 5 and 6 select level 0 only when the field equals 3 and their own enable bit (0x84 bit 22 for pin 5, bit 23 for pin 6) is 1. They select level 1 when that bit is 1 under any other mode, and otherwise 7.
- R10: Pin 7 selects level 0 when 0xA0 bit 0 is 1. Otherwise it selects level 1 when strap bit 6 is 0, and otherwise 7 (the fallback).
- R11: `pin_drv[p]` equals `src_in[3p+k]`, where k is 0 for code 0, 1 for code 1 and 2 for code 7. The other two sources of that pin have no effect on it.
- R12: `pin_sel[3p+2:3p]` holds pin p's code: 0 to 4 for the winning priority level, 7 for the fallback. No other value ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the control bank |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| strap_a | input | 32 | First strap word, also used by pin enables |
| strap_b | input | 32 | Second strap word, readback only |
| src_in | input | 24 | Candidate sources, three per pin: level 0, level 1, fallback |
| pin_sel | output | 24 | Registered 3-bit selection code per pin |
| pin_drv | output | 8 | Signal routed to each pin |

## Verification
Each pin is driven through the patterns that separate its levels. The top level alone shows the override. The lower level alone shows the fall-through. With both set, priority is exposed, and releasing the top level shows the return to the lower one. The OR pins are enabled once from a register bit and once from a strap bit, each alone, so a dropped OR-term becomes visible. The three-bit AND pin is broken one input at a time. The video pins are swept over all four mode values, so a mistake of "nonzero" against "equals 3" shows as a miscompare. Strap and unmapped writes are followed by readbacks and selection checks, and the latency test samples both the capturing edge and the next one.

// File: rtl/pinmux_pkg.sv
// Package: shared constants, register offsets and helpers for the pin
// function multiplexer. Assumes byte offsets fit in 8 bits.
package pinmux_pkg;

    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int NREG     = 12;
    localparam int SLOT_W   = $clog2(NREG + 1);
    localparam int NPIN     = 8;
    localparam int NLVL     = 5;
    localparam int NSRC     = 3;
    localparam int SEL_W    = 3;

    localparam logic [SEL_W-1:0]  SEL_FALLBACK = 3'd7;
    localparam logic [SLOT_W-1:0] SLOT_MISS    = SLOT_W'(NREG);

    typedef logic [WORD_W-1:0] word_t;

    // Writable register slots (storage order; bus offset decoded below)
    localparam int IX_MISC  = 0;
    localparam int IX_RSTC  = 1;
    localparam int IX_MACD  = 2;
    localparam int IX_FN1   = 3;
    localparam int IX_FN2   = 4;
    localparam int IX_FN3   = 5;
    localparam int IX_FN4   = 6;
    localparam int IX_FN5   = 7;
    localparam int IX_FN6   = 8;
    localparam int IX_FN7   = 9;
    localparam int IX_FN8   = 10;
    localparam int IX_FN9   = 11;

    localparam logic [ADDR_W-1:0] OFF_STRAP_A = 8'h70;
    localparam logic [ADDR_W-1:0] OFF_STRAP_B = 8'hD0;

    // Map a bus offset to a storage slot, or SLOT_MISS when not writable.
    function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
        case (a)
            8'h2C:   return SLOT_W'(IX_MISC);
            8'h3C:   return SLOT_W'(IX_RSTC);
            8'h48:   return SLOT_W'(IX_MACD);
            8'h80:   return SLOT_W'(IX_FN1);
            8'h84:   return SLOT_W'(IX_FN2);
            8'h88:   return SLOT_W'(IX_FN3);
            8'h8C:   return SLOT_W'(IX_FN4);
            8'h90:   return SLOT_W'(IX_FN5);
            8'h94:   return SLOT_W'(IX_FN6);
            8'hA0:   return SLOT_W'(IX_FN7);
            8'hA4:   return SLOT_W'(IX_FN8);
            8'hA8:   return SLOT_W'(IX_FN9);
            default: return SLOT_MISS;
        endcase
    endfunction

    // Descriptor compare: masked field of a word equals an enable value.
    function automatic logic fld_eq(input word_t w, input word_t mask, input word_t val);
        return (w & mask) == (val & mask);
    endfunction

endpackage

// File: rtl/pinmux_regbank.sv
// Control register bank with strap readback.
// Holds NREG writable words; strap words are read-only inputs.
// Assumes a single-cycle write strobe and combinational read.
module pinmux_regbank
    import pinmux_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  word_t                    wdata,
    input  word_t                    strap_a,
    input  word_t                    strap_b,
    output word_t                    rdata,
    output logic [NREG-1:0][WORD_W-1:0] regs_q
);

    logic [SLOT_W-1:0] slot;
    assign slot = slot_of(addr);

    // Capture writes to writable slots; strap and unmapped writes are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (we && (slot != SLOT_MISS)) begin
            regs_q[slot] <= wdata;
        end
    end

    // Read mux: strap words, stored words, zero elsewhere.
    always_comb begin
        if (addr == OFF_STRAP_A)      rdata = strap_a;
        else if (addr == OFF_STRAP_B) rdata = strap_b;
        else if (slot != SLOT_MISS)   rdata = regs_q[slot];
        else                          rdata = '0;
    end

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && slot != SLOT_MISS) |=> (regs_q[$past(slot)] == $past(wdata))); // R2

    AST_RO_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && slot == SLOT_MISS) |=> $stable(regs_q)); // R3 R4

endmodule

// File: rtl/pinmux_expr_eval.sv
// Enable-expression evaluator: for each pin and priority level, the OR of
// AND-terms of descriptor compares over control words and strap_a.
// Undefined levels are held false. Purely combinational.
module pinmux_expr_eval
    import pinmux_pkg::*;
(
    input  logic [NREG-1:0][WORD_W-1:0] regs,
    input  word_t                       strap,
    output logic [NPIN-1:0][NLVL-1:0]   lvl_en
);

    word_t r_rst, r_fn1, r_fn2, r_fn5, r_fn7, r_fn8;
    assign r_rst = regs[IX_RSTC];
    assign r_fn1 = regs[IX_FN1];
    assign r_fn2 = regs[IX_FN2];
    assign r_fn5 = regs[IX_FN5];
    assign r_fn7 = regs[IX_FN7];
    assign r_fn8 = regs[IX_FN8];

    localparam word_t VMODE_M = 32'h0000_0030;

    // Per-pin level enables built from descriptor compares.
    always_comb begin
        lvl_en = '0;
        // pin 0: two levels from different registers
        lvl_en[0][0] = fld_eq(r_fn5, 32'h0040_0000, 32'h0040_0000);
        lvl_en[0][1] = fld_eq(r_fn1, 32'h0000_0010, 32'h0000_0010);
        // pin 1: register bit OR strap bit
        lvl_en[1][0] = fld_eq(r_fn1, 32'h0000_1000, 32'h0000_1000)
                     | fld_eq(strap, 32'h0000_4000, 32'h0000_4000);
        // pin 2: top level single bit; lower level register OR inverted strap
        lvl_en[2][0] = fld_eq(r_fn1, 32'h0200_0000, 32'h0200_0000);
        lvl_en[2][1] = fld_eq(r_fn8, 32'h0000_1000, 32'h0000_1000)
                     | fld_eq(strap, 32'h0008_0000, 32'h0000_0000);
        // pin 3: three-register AND, split by one bit
        lvl_en[3][0] = fld_eq(r_rst, 32'h0000_0008, 32'h0000_0008)
                     & fld_eq(r_fn1, 32'h0000_8000, 32'h0000_8000)
                     & fld_eq(r_fn5, 32'h8000_0000, 32'h0000_0000);
        lvl_en[3][1] = fld_eq(r_rst, 32'h0000_0008, 32'h0000_0008)
                     & fld_eq(r_fn1, 32'h0000_8000, 32'h0000_8000)
                     & fld_eq(r_fn5, 32'h8000_0000, 32'h8000_0000);
        // pin 4: any enabled video mode (OR over the three nonzero codes)
        lvl_en[4][0] = (fld_eq(r_fn5, VMODE_M, 32'h0000_0010)
                      | fld_eq(r_fn5, VMODE_M, 32'h0000_0020)
                      | fld_eq(r_fn5, VMODE_M, 32'h0000_0030))
                     & fld_eq(r_fn2, 32'h0002_0000, 32'h0002_0000);
        lvl_en[4][1] = fld_eq(r_fn2, 32'h0002_0000, 32'h0002_0000);
        // pins 5 and 6: only the widest video mode, each with its own bit
        lvl_en[5][0] = fld_eq(r_fn5, VMODE_M, 32'h0000_0030)
                     & fld_eq(r_fn2, 32'h0040_0000, 32'h0040_0000);
        lvl_en[5][1] = fld_eq(r_fn2, 32'h0040_0000, 32'h0040_0000);
        lvl_en[6][0] = fld_eq(r_fn5, VMODE_M, 32'h0000_0030)
                     & fld_eq(r_fn2, 32'h0080_0000, 32'h0080_0000);
        lvl_en[6][1] = fld_eq(r_fn2, 32'h0080_0000, 32'h0080_0000);
        // pin 7: GPIO on top, strap-selected level below, clock fallback
        lvl_en[7][0] = fld_eq(r_fn7, 32'h0000_0001, 32'h0000_0001);
        lvl_en[7][1] = fld_eq(strap, 32'h0000_0040, 32'h0000_0000);
    end

endmodule

// File: rtl/pinmux_prio_pin.sv
// Per-pin priority resolver: picks the lowest-numbered enabled level,
// registers the code (SEL_FALLBACK when none), and routes the source.
// Assumes source slot k serves level k and the last slot the fallback.
module pinmux_prio_pin
    import pinmux_pkg::*;
#(
    parameter int LVLS = NLVL,
    parameter int SRCS = NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVLS-1:0]  en,
    input  logic [SRCS-1:0]  src,
    output logic [SEL_W-1:0] sel_q,
    output logic             drv
);

    logic [SEL_W-1:0] sel_nxt;
    logic             armed_q;

    // Priority encode: level 0 highest, fallback when nothing enabled.
    always_comb begin
        sel_nxt = SEL_FALLBACK;
        for (int i = LVLS - 1; i >= 0; i--) begin
            if (en[i]) sel_nxt = SEL_W'(i);
        end
    end

    // Hold the resolved code; reset to the fallback.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= SEL_FALLBACK;
        else        sel_q <= sel_nxt;
    end

    // Marks that sel_q was loaded from en on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // Route the source that matches the held code.
    always_comb begin
        if (sel_q == SEL_FALLBACK)            drv = src[SRCS-1];
        else if (int'(sel_q) < SRCS - 1)      drv = src[sel_q];
        else                                  drv = 1'b0;
    end

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_FALLBACK) || (int'(sel_q) < LVLS)); // R12

    AST_FALLBACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && sel_q == SEL_FALLBACK) |-> ($past(en) == '0)); // R10

    AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && sel_q != SEL_FALLBACK) |-> ((($past(en) >> sel_q) & LVLS'(1)) != '0)); // R6

    AST_NO_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && sel_q != SEL_FALLBACK) |-> (($past(en) & LVLS'((1 << sel_q) - 1)) == '0)); // R6

endmodule

// File: rtl/pin_function_mux.sv
// Top: control bank, enable evaluation and one resolver per pin.
// Assumes strap inputs are quasi-static; a change is seen one edge later.
module pin_function_mux
    import pinmux_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    input  logic [WORD_W-1:0]       strap_a,
    input  logic [WORD_W-1:0]       strap_b,
    input  logic [NPIN*NSRC-1:0]    src_in,
    output logic [NPIN*SEL_W-1:0]   pin_sel,
    output logic [NPIN-1:0]         pin_drv
);

    logic [NREG-1:0][WORD_W-1:0] regs_q;
    logic [NPIN-1:0][NLVL-1:0]   lvl_en;

    pinmux_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .strap_a (strap_a),
        .strap_b (strap_b),
        .rdata   (bus_rdata),
        .regs_q  (regs_q)
    );

    pinmux_expr_eval u_eval (
        .regs   (regs_q),
        .strap  (strap_a),
        .lvl_en (lvl_en)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        pinmux_prio_pin #(.LVLS(NLVL), .SRCS(NSRC)) u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (lvl_en[p]),
            .src   (src_in[p*NSRC +: NSRC]),
            .sel_q (pin_sel[p*SEL_W +: SEL_W]),
            .drv   (pin_drv[p])
        );
    end

endmodule

// File: tb/tb_pin_function_mux.sv
`timescale 1ns/1ps
module tb_pin_function_mux;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] strap_a = 32'h0008_0040;
    logic [31:0] strap_b = 32'hA5A5_0F0F;
    logic [23:0] src_in = '0;
    logic [23:0] pin_sel;
    logic [7:0]  pin_drv;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    pin_function_mux dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_a(strap_a),
        .strap_b(strap_b), .src_in(src_in), .pin_sel(pin_sel), .pin_drv(pin_drv)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sel(input int p);
        return 32'(pin_sel[p*3 +: 3]);
    endfunction

    // Write one word; returns at the negedge after the capturing edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Write and wait for the selection edge.
    task automatic wrs(input logic [7:0] a, input logic [31:0] d);
        wr(a, d);
        @(negedge clk);
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic set_strap(input logic [31:0] v);
        @(negedge clk);
        strap_a = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd_check("R1 reg 0x80 zero", 8'h80, 32'h0);
        rd_check("R1 reg 0x90 zero", 8'h90, 32'h0);
        rd_check("R1 reg 0xA8 zero", 8'hA8, 32'h0);
        check("R1 all pins fallback", 32'(pin_sel), 32'hFF_FFFF);
    endtask

    task automatic t_regs();
        logic [7:0] offs [12] = '{8'h2C, 8'h3C, 8'h48, 8'h80, 8'h84, 8'h88,
                                  8'h8C, 8'h90, 8'h94, 8'hA0, 8'hA4, 8'hA8};
        for (int i = 0; i < 12; i++) wr(offs[i], 32'h5A00_0000 | 32'(offs[i]) << 8 | 32'(i));
        for (int i = 0; i < 12; i++)
            rd_check("R2 readback", offs[i], 32'h5A00_0000 | 32'(offs[i]) << 8 | 32'(i));
        for (int i = 0; i < 12; i++) wr(offs[i], 32'h0);
        @(negedge clk);
        rd_check("R2 cleared", 8'h90, 32'h0);
        check("R2 pins back to fallback", 32'(pin_sel), 32'hFF_FFFF);
    endtask

    task automatic t_strap_ro();
        rd_check("R3 strap a read", 8'h70, 32'h0008_0040);
        rd_check("R3 strap b read", 8'hD0, 32'hA5A5_0F0F);
        wrs(8'h70, 32'hFFFF_FFFF);
        wrs(8'hD0, 32'h0000_0000);
        rd_check("R3 strap a after write", 8'h70, 32'h0008_0040);
        rd_check("R3 strap b after write", 8'hD0, 32'hA5A5_0F0F);
        rd_check("R3 no spill into 0x80", 8'h80, 32'h0);
        check("R3 pins unchanged", 32'(pin_sel), 32'hFF_FFFF);
    endtask

    task automatic t_unmapped();
        wrs(8'h74, 32'hFFFF_FFFF);
        wrs(8'h81, 32'hFFFF_FFFF);
        rd_check("R4 unmapped reads zero", 8'h74, 32'h0);
        rd_check("R4 0x80 untouched", 8'h80, 32'h0);
        rd_check("R4 0x84 untouched", 8'h84, 32'h0);
        check("R4 pins unchanged", 32'(pin_sel), 32'hFF_FFFF);
    endtask

    task automatic t_latency();
        wr(8'h90, 32'h0040_0000);
        check("R5 not on capture edge", sel(0), 32'd7);
        @(negedge clk);
        check("R5 one edge later", sel(0), 32'd0);
        wrs(8'h90, 32'h0);
    endtask

    task automatic t_prio();
        wrs(8'h80, 32'h0000_0010);
        check("R6 low level alone", sel(0), 32'd1);
        wrs(8'h90, 32'h0040_0000);
        check("R6 high level wins", sel(0), 32'd0);
        wrs(8'h80, 32'h0);
        check("R6 high level alone", sel(0), 32'd0);
        wrs(8'h80, 32'h0000_0010);
        wrs(8'h90, 32'h0);
        check("R6 return to low level", sel(0), 32'd1);
        wrs(8'h80, 32'h0);
        check("R6 none enabled", sel(0), 32'd7);
    endtask

    task automatic t_or_terms();
        wrs(8'h80, 32'h0000_1000);
        check("R7 pin1 by register", sel(1), 32'd0);
        wrs(8'h80, 32'h0);
        set_strap(32'h0008_4040);
        check("R7 pin1 by strap", sel(1), 32'd0);
        set_strap(32'h0008_0040);
        check("R7 pin1 off", sel(1), 32'd7);
        set_strap(32'h0000_0040);
        check("R7 pin2 by strap low", sel(2), 32'd1);
        wrs(8'h80, 32'h0200_0000);
        check("R7 pin2 top over strap", sel(2), 32'd0);
        wrs(8'h80, 32'h0);
        set_strap(32'h0008_0040);
        check("R7 pin2 off", sel(2), 32'd7);
        wrs(8'hA4, 32'h0000_1000);
        check("R7 pin2 by register", sel(2), 32'd1);
        wrs(8'hA4, 32'h0);
    endtask

    task automatic t_and3();
        wr(8'h3C, 32'h8);
        wrs(8'h80, 32'h0000_8000);
        check("R8 level 0 with bit31 clear", sel(3), 32'd0);
        wrs(8'h90, 32'h8000_0000);
        check("R8 level 1 with bit31 set", sel(3), 32'd1);
        wrs(8'h3C, 32'h0);
        check("R8 missing reset-ctl bit", sel(3), 32'd7);
        wr(8'h3C, 32'h8);
        wrs(8'h80, 32'h0);
        check("R8 missing fn1 bit", sel(3), 32'd7);
        wr(8'h3C, 32'h0);
        wrs(8'h90, 32'h0);
    endtask

    task automatic t_video();
        wr(8'h84, 32'h00C2_0000);
        for (int m = 0; m < 4; m++) begin
            wrs(8'h90, 32'(m) << 4);
            check("R9 pin4 mode sweep", sel(4), (m != 0) ? 32'd0 : 32'd1);
            check("R9 pin5 mode sweep", sel(5), (m == 3) ? 32'd0 : 32'd1);
            check("R9 pin6 mode sweep", sel(6), (m == 3) ? 32'd0 : 32'd1);
        end
        wrs(8'h84, 32'h0040_0000);
        check("R9 pin5 own bit", sel(5), 32'd0);
        check("R9 pin6 bit clear", sel(6), 32'd7);
        check("R9 pin4 bit clear", sel(4), 32'd7);
        wr(8'h84, 32'h0);
        wrs(8'h90, 32'h0);
    endtask

    task automatic t_fallback();
        check("R10 fallback at idle", sel(7), 32'd7);
        wrs(8'hA0, 32'h1);
        check("R10 top level", sel(7), 32'd0);
        set_strap(32'h0008_0000);
        check("R10 top over strap level", sel(7), 32'd0);
        wrs(8'hA0, 32'h0);
        check("R10 strap level", sel(7), 32'd1);
        set_strap(32'h0008_0040);
        check("R10 back to fallback", sel(7), 32'd7);
    endtask

    task automatic t_route();
        // pin 0 on level 1: slot 1 drives, slots 0 and 2 ignored
        wrs(8'h80, 32'h0000_0010);
        src_in = 24'h0;
        src_in[1] = 1'b1;
        #1 check("R11 pin0 slot1 high", 32'(pin_drv[0]), 32'd1);
        src_in = 24'h0;
        src_in[0] = 1'b1; src_in[2] = 1'b1;
        #1 check("R11 pin0 other slots ignored", 32'(pin_drv[0]), 32'd0);
        // pin 7 on fallback: slot 2
        src_in = 24'h0;
        src_in[7*3+2] = 1'b1;
        #1 check("R11 pin7 fallback slot", 32'(pin_drv[7]), 32'd1);
        src_in[7*3+0] = 1'b1; src_in[7*3+2] = 1'b0;
        #1 check("R11 pin7 level0 slot ignored", 32'(pin_drv[7]), 32'd0);
        // pin 7 on level 0: slot 0
        wrs(8'hA0, 32'h1);
        check("R11 pin7 level0 slot", 32'(pin_drv[7]), 32'd1);
        wr(8'hA0, 32'h0);
        wrs(8'h80, 32'h0);
        src_in = 24'h0;
        check("R12 all codes fallback", 32'(pin_sel), 32'hFF_FFFF);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_strap_ro();
        t_unmapped();
        t_latency();
        t_prio();
        t_or_terms();
        t_and3();
        t_video();
        t_fallback();
        t_route();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule